// File: doc/BRIEF.md
# Load Request Classifier and Router

This block sits between a load or instruction-fetch requester and the memory system. Each request carries an address, a log2 byte size, an access type and three ordering flags (acquire, release, reserve). The block first checks alignment for ordered or reserved loads. It then turns the flag combination into an ordering kind, or rejects it as unsupported. Next it applies the outcome of an external protection check, and finally routes the request to a device-register port, to a RAM port, or straight to a fault.

Protection rule evaluation, the RAM and the device models all sit outside this block. They are represented by region-match inputs (`dev_hit`, `ram_hit`), a protection verdict input, and simple one-pulse request/response ports. The requester issues one request at a time and waits for its single response pulse. A response is either zero-extended read data, an exception code, or a not-implemented indication.

Top module: `load_dispatch`

## Requirements
- R1: A request with acquire or reserve set whose address has any of its low `req_size` bits nonzero completes with exception code 4 (load address misaligned). No memory port is touched, and this takes precedence over every other check.
- R2: A request sent to RAM carries `ram_order` as follows: no flags = 0 (plain), acquire = 1, acquire+release = 2 (strong acquire), reserve = 3, acquire+reserve = 4, all three = 5.
- R3: Release without acquire (with reserve set or clear) pulses `rsp_unimpl`, raises no exception, and touches no memory port.
- R4: When `prot_en` is 1 and `prot_fault` is 1, the request completes with exception code `prot_code` and touches no memory port. When `prot_en` is 0, `prot_fault` has no effect.
- R5: A request with `dev_hit` set goes to the device port with its address and size, even when `ram_hit` is also set. Otherwise a request with `ram_hit` set goes to the RAM port.
- R6: A request with neither region hit completes with exception code 5 (load access fault).
- R7: If RAM answers with `ram_reject`, the exception code follows the access type of the request: type 0 (fetch) gives 1, type 1 (data read) gives 5, and types 2 and 3 give 7 (store/AMO access fault).
- R8: Each request yields exactly one single-cycle response, with at most one of `rsp_valid`, `rsp_exc` and `rsp_unimpl` high. Read data is zero-extended above 8<<size bits. `rsp_data` is 0 with an exception, and `rsp_code` is 0 with data.
- R9: While a device or RAM access is outstanding, `req_valid` is ignored: no new port request is issued and no extra response appears.
- R10: Completions that need no memory respond in the cycle after acceptance. A port request is issued in the cycle after acceptance, and its response appears in the cycle after `dev_rvalid`, `ram_rvalid` or `ram_reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | log2 of the access width in bytes |
| req_type | input | 2 | 0 fetch, 1 data read, 2/3 other |
| req_acq | input | 1 | Acquire flag |
| req_rel | input | 1 | Release flag |
| req_rsv | input | 1 | Reservation flag |
| prot_en | input | 1 | Protection check enabled |
| prot_fault | input | 1 | Protection check reports a fault |
| prot_code | input | 4 | Exception code of the protection fault |
| dev_hit | input | 1 | Whole access lies in a readable device region |
| ram_hit | input | 1 | Whole access lies in RAM |
| dev_req | output | 1 | Device read pulse |
| dev_addr | output | AW | Device read address |
| dev_size | output | 2 | Device read size |
| dev_rvalid | input | 1 | Device read data valid |
| dev_rdata | input | 64 | Device read data |
| ram_req | output | 1 | RAM read pulse |
| ram_addr | output | AW | RAM read address |
| ram_size | output | 2 | RAM read size |
| ram_order | output | 3 | Ordering kind of the RAM read |
| ram_rvalid | input | 1 | RAM read data valid |
| ram_reject | input | 1 | RAM cannot serve this ordering kind |
| ram_rdata | input | 64 | RAM read data |
| rsp_valid | output | 1 | Read data response pulse |
| rsp_data | output | 64 | Zero-extended read data |
| rsp_exc | output | 1 | Exception response pulse |
| rsp_code | output | 4 | Exception code |
| rsp_unimpl | output | 1 | Unsupported flag combination pulse |

## Verification
Inputs change on the falling edge and outputs are sampled on the next falling edge. A request therefore has been taken at the rising edge in between. Faults, not-implemented results and port requests are due at exactly that first falling edge, and the bench checks them there. A memory response is checked exactly one falling edge after the bench raised the port's valid or reject. Between requests the bench also confirms that every strobe is low. This is how a pulse that lasts too long, or a response that comes early or late, is caught.

// File: rtl/load_dispatch.sv
module load_dispatch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [1:0]    req_type,
  input  logic          req_acq,
  input  logic          req_rel,
  input  logic          req_rsv,
  input  logic          prot_en,
  input  logic          prot_fault,
  input  logic [3:0]    prot_code,
  input  logic          dev_hit,
  input  logic          ram_hit,
  output logic          dev_req,
  output logic [AW-1:0] dev_addr,
  output logic [1:0]    dev_size,
  input  logic          dev_rvalid,
  input  logic [63:0]   dev_rdata,
  output logic          ram_req,
  output logic [AW-1:0] ram_addr,
  output logic [1:0]    ram_size,
  output logic [2:0]    ram_order,
  input  logic          ram_rvalid,
  input  logic          ram_reject,
  input  logic [63:0]   ram_rdata,
  output logic          rsp_valid,
  output logic [63:0]   rsp_data,
  output logic          rsp_exc,
  output logic [3:0]    rsp_code,
  output logic          rsp_unimpl
);
  localparam logic [3:0] C_FETCH_ACC = 4'd1;
  localparam logic [3:0] C_LOAD_MIS  = 4'd4;
  localparam logic [3:0] C_LOAD_ACC  = 4'd5;
  localparam logic [3:0] C_STORE_ACC = 4'd7;

  typedef enum logic [1:0] {S_IDLE, S_DEV, S_RAM} st_t;
  st_t st;
  logic [1:0] type_q, size_q;
  logic [2:0] amask, order;

  always_comb begin
    case (req_size)
      2'd0: amask = 3'b000;
      2'd1: amask = 3'b001;
      2'd2: amask = 3'b011;
      default: amask = 3'b111;
    endcase
  end

  wire take   = req_valid && (st == S_IDLE);
  wire misal  = (req_acq | req_rsv) && |(req_addr[2:0] & amask);
  wire unimpl = req_rel & ~req_acq;
  wire pfault = prot_en & prot_fault;

  always_comb begin
    case ({req_acq, req_rel, req_rsv})
      3'b100:  order = 3'd1;
      3'b110:  order = 3'd2;
      3'b001:  order = 3'd3;
      3'b101:  order = 3'd4;
      3'b111:  order = 3'd5;
      default: order = 3'd0;
    endcase
  end

  function automatic logic [63:0] zext(input logic [63:0] d, input logic [1:0] sz);
    case (sz)
      2'd0: return {56'd0, d[7:0]};
      2'd1: return {48'd0, d[15:0]};
      2'd2: return {32'd0, d[31:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [3:0] reject_code(input logic [1:0] t);
    case (t)
      2'd0: return C_FETCH_ACC;
      2'd1: return C_LOAD_ACC;
      default: return C_STORE_ACC;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      type_q <= '0;
      size_q <= '0;
      dev_req <= 1'b0;
      dev_addr <= '0;
      dev_size <= '0;
      ram_req <= 1'b0;
      ram_addr <= '0;
      ram_size <= '0;
      ram_order <= '0;
      rsp_valid <= 1'b0;
      rsp_data <= '0;
      rsp_exc <= 1'b0;
      rsp_code <= '0;
      rsp_unimpl <= 1'b0;
    end else begin
      dev_req <= 1'b0;
      ram_req <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data <= '0;
      rsp_exc <= 1'b0;
      rsp_code <= '0;
      rsp_unimpl <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          type_q <= req_type;
          size_q <= req_size;
          if (misal) begin
            rsp_exc <= 1'b1;
            rsp_code <= C_LOAD_MIS;
          end else if (unimpl) begin
            rsp_unimpl <= 1'b1;
          end else if (pfault) begin
            rsp_exc <= 1'b1;
            rsp_code <= prot_code;
          end else if (dev_hit) begin
            dev_req <= 1'b1;
            dev_addr <= req_addr;
            dev_size <= req_size;
            st <= S_DEV;
          end else if (ram_hit) begin
            ram_req <= 1'b1;
            ram_addr <= req_addr;
            ram_size <= req_size;
            ram_order <= order;
            st <= S_RAM;
          end else begin
            rsp_exc <= 1'b1;
            rsp_code <= C_LOAD_ACC;
          end
        end
        S_DEV: if (dev_rvalid) begin
          rsp_valid <= 1'b1;
          rsp_data <= zext(dev_rdata, size_q);
          st <= S_IDLE;
        end
        S_RAM: if (ram_reject) begin
          rsp_exc <= 1'b1;
          rsp_code <= reject_code(type_q);
          st <= S_IDLE;
        end else if (ram_rvalid) begin
          rsp_valid <= 1'b1;
          rsp_data <= zext(ram_rdata, size_q);
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    take && misal |=> rsp_exc && rsp_code == C_LOAD_MIS && !dev_req && !ram_req);

  a_r2_order_range: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |-> ram_order <= 3'd5);

  a_r2_strong_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_acq && req_rel && req_rsv && !misal && !pfault && !dev_hit && ram_hit
    |=> ram_req && ram_order == 3'd5);

  a_r3_unimpl_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    take && !misal && unimpl |=> rsp_unimpl && !rsp_exc && !dev_req && !ram_req);

  a_r4_prot_code: assert property (@(posedge clk) disable iff (!rst_n)
    take && !misal && !unimpl && pfault |=> rsp_exc && rsp_code == $past(prot_code));

  a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_req && ram_req));

  a_r8_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, rsp_exc, rsp_unimpl}));

  a_r9_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req || ram_req) |=> !dev_req && !ram_req);
endmodule

// File: tb/tb_load_dispatch.sv
module tb_load_dispatch;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_acq = 0, req_rel = 0, req_rsv = 0;
  logic [AW-1:0] req_addr = 0;
  logic [1:0] req_size = 0, req_type = 0;
  logic prot_en = 0, prot_fault = 0, dev_hit = 0, ram_hit = 0;
  logic [3:0] prot_code = 0;
  logic dev_rvalid = 0, ram_rvalid = 0, ram_reject = 0;
  logic [63:0] dev_rdata = 0, ram_rdata = 0;
  logic dev_req, ram_req, rsp_valid, rsp_exc, rsp_unimpl;
  logic [AW-1:0] dev_addr, ram_addr;
  logic [1:0] dev_size, ram_size;
  logic [2:0] ram_order;
  logic [63:0] rsp_data;
  logic [3:0] rsp_code;
  int checks = 0, failures = 0, cycles = 0;

  load_dispatch #(.AW(AW)) dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", rq, msg);
    end
  endtask

  function automatic int exp_order(input bit a, input bit r, input bit s);
    case ({a, r, s})
      3'b100: return 1;
      3'b110: return 2;
      3'b001: return 3;
      3'b101: return 4;
      3'b111: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] exp_zx(input logic [63:0] d, input logic [1:0] sz);
    if (sz == 2'd3) return d;
    return d & ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  // 0 misaligned, 1 unimpl, 2 protection, 3 device, 4 ram, 5 no region
  function automatic int exp_class(input logic [AW-1:0] a, input logic [1:0] sz,
      input bit aq, input bit rl, input bit rs, input bit pe, input bit pf, input bit dh, input bit rh);
    if ((aq || rs) && (a % (1 << sz)) != 0) return 0;
    if (rl && !aq) return 1;
    if (pe && pf) return 2;
    if (dh) return 3;
    if (rh) return 4;
    return 5;
  endfunction

  function automatic logic [3:0] exp_rej(input logic [1:0] t);
    return (t == 0) ? 4'd1 : (t == 1) ? 4'd5 : 4'd7;
  endfunction

  task automatic quiet(input string rq);
    chk(!rsp_valid && !rsp_exc && !rsp_unimpl && !dev_req && !ram_req, rq,
        $sformatf("strobes v=%0b e=%0b u=%0b d=%0b r=%0b expected all 0",
                  rsp_valid, rsp_exc, rsp_unimpl, dev_req, ram_req));
  endtask

  task automatic run_one(input logic [AW-1:0] a, input logic [1:0] sz, input logic [1:0] t,
      input bit aq, input bit rl, input bit rs, input bit pe, input bit pf, input logic [3:0] pc,
      input bit dh, input bit rh, input bit rej, input logic [63:0] d, input bit busy_poke);
    int c;
    quiet("R8");
    req_addr = a; req_size = sz; req_type = t; req_acq = aq; req_rel = rl; req_rsv = rs;
    prot_en = pe; prot_fault = pf; prot_code = pc; dev_hit = dh; ram_hit = rh;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    c = exp_class(a, sz, aq, rl, rs, pe, pf, dh, rh);
    case (c)
      0: chk(rsp_exc && rsp_code == 4 && rsp_data == 0 && !dev_req && !ram_req, "R1",
             $sformatf("exc=%0b code=%0d expected exc=1 code=4", rsp_exc, rsp_code));
      1: chk(rsp_unimpl && !rsp_exc && !rsp_valid && !dev_req && !ram_req, "R3",
             $sformatf("unimpl=%0b exc=%0b expected 1/0", rsp_unimpl, rsp_exc));
      2: chk(rsp_exc && rsp_code == pc && !dev_req && !ram_req, "R4",
             $sformatf("exc=%0b code=%0d expected 1/%0d", rsp_exc, rsp_code, pc));
      5: chk(rsp_exc && rsp_code == 5 && !dev_req && !ram_req, "R6",
             $sformatf("exc=%0b code=%0d expected 1/5", rsp_exc, rsp_code));
      default: begin
        if (c == 3)
          chk(dev_req && !ram_req && dev_addr == a && dev_size == sz, "R5",
              $sformatf("dev_req=%0b addr=%h size=%0d expected 1/%h/%0d", dev_req, dev_addr, dev_size, a, sz));
        else begin
          chk(ram_req && !dev_req && ram_addr == a && ram_size == sz, "R5",
              $sformatf("ram_req=%0b addr=%h expected 1/%h", ram_req, ram_addr, a));
          chk(ram_order == exp_order(aq, rl, rs), "R2",
              $sformatf("order=%0d expected %0d", ram_order, exp_order(aq, rl, rs)));
        end
        chk(!rsp_valid && !rsp_exc && !rsp_unimpl, "R10",
            $sformatf("early response v=%0b e=%0b expected none", rsp_valid, rsp_exc));
        if (busy_poke) begin
          req_addr = a ^ 32'h100; req_acq = 0; req_rel = 0; req_rsv = 0;
          prot_en = 0; dev_hit = ~dh; ram_hit = 1; req_valid = 1;
          @(negedge clk);
          req_valid = 0;
          quiet("R9");
        end
        if (c == 3) begin dev_rdata = d; dev_rvalid = 1; end
        else begin ram_rdata = d; ram_rvalid = !rej; ram_reject = rej; end
        @(negedge clk);
        dev_rvalid = 0; ram_rvalid = 0; ram_reject = 0;
        if (c == 4 && rej)
          chk(rsp_exc && !rsp_valid && rsp_code == exp_rej(t) && rsp_data == 0, "R7",
              $sformatf("exc=%0b code=%0d expected 1/%0d", rsp_exc, rsp_code, exp_rej(t)));
        else
          chk(rsp_valid && !rsp_exc && rsp_code == 0 && rsp_data == exp_zx(d, sz), "R8",
              $sformatf("valid=%0b data=%h expected 1/%h", rsp_valid, rsp_data, exp_zx(d, sz)));
      end
    endcase
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    quiet("R8");
    chk(rsp_data == 0 && rsp_code == 0, "R8",
        $sformatf("reset data=%h code=%0d expected 0/0", rsp_data, rsp_code));
    // R1: misaligned acquire beats unimpl, protection and region routing
    run_one(32'h1002, 2, 1, 1, 0, 0, 1, 1, 4'd9, 1, 1, 0, 64'h1, 0);
    run_one(32'h1001, 1, 1, 0, 1, 1, 0, 0, 0, 0, 1, 0, 64'h1, 0);
    // plain misaligned load is not an alignment fault
    run_one(32'h1003, 3, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 64'h1122334455667788, 0);
    // R3: both unsupported combinations
    run_one(32'h2000, 2, 1, 0, 1, 0, 0, 0, 0, 0, 1, 0, 64'h0, 0);
    run_one(32'h2000, 2, 1, 0, 1, 1, 0, 0, 0, 1, 1, 0, 64'h0, 0);
    // R4: protection fault, and fault ignored when disabled
    run_one(32'h3000, 2, 0, 0, 0, 0, 1, 1, 4'd11, 1, 1, 0, 64'h0, 0);
    run_one(32'h3000, 2, 0, 0, 0, 0, 0, 1, 4'd11, 0, 1, 0, 64'hAABBCCDD_EEFF0011, 0);
    // R5: device wins over RAM; R6: no region
    run_one(32'h4000, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFA5, 0);
    run_one(32'h5000, 3, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 64'h0, 0);
    // R2: all six orderings; R7: reject by type
    run_one(32'h6000, 3, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 64'h5, 0);
    run_one(32'h6000, 3, 1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 64'h6, 0);
    run_one(32'h6000, 3, 1, 1, 1, 0, 0, 0, 0, 0, 1, 0, 64'h7, 0);
    run_one(32'h6000, 3, 1, 0, 0, 1, 0, 0, 0, 0, 1, 0, 64'h8, 0);
    run_one(32'h6000, 3, 1, 1, 0, 1, 0, 0, 0, 0, 1, 0, 64'h9, 0);
    run_one(32'h6000, 3, 1, 1, 1, 1, 0, 0, 0, 0, 1, 0, 64'hA, 0);
    run_one(32'h7000, 2, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 64'h0, 0);
    run_one(32'h7000, 2, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 64'h0, 0);
    run_one(32'h7000, 2, 2, 0, 0, 0, 0, 0, 0, 0, 1, 1, 64'h0, 0);
    run_one(32'h7000, 2, 3, 0, 0, 0, 0, 0, 0, 0, 1, 1, 64'h0, 0);
    // R9: requests while busy are ignored
    run_one(32'h8000, 1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 64'h1234_5678_9ABC_DEF0, 1);
    run_one(32'h8000, 2, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 64'h1234_5678_9ABC_DEF0, 1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      run_one({$urandom} & 32'hFFFF_FFFF, r[1:0], r[3:2], r[4], r[5], r[6], r[7], r[8], r[12:9],
              r[13], r[14], r[15], {$urandom, $urandom}, r[16] & r[17]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule